// File: doc/BRIEF.md
# SPI Host Register Block

This block is a byte-wide SPI master controlled through three registers on a simple processor-style bus. Software sets the SCK idle level, the sampling edge, the bit order, the SCK rate and the interrupt enable in a control register, then writes a byte to the data register. That write starts an 8-bit exchange: the byte is shifted out on MOSI while MISO is shifted in. When the last bit has been taken in, a completion flag rises in the status register. Software then reads the received byte from the data register.

A write to the data register during an exchange is dropped and leaves a collision mark in the status register. Both marks are cleared by reading the status register while the completion flag is set and then reading or writing the data register. The interrupt request follows the completion flag whenever interrupts are enabled. Chip select is not produced here; a general-purpose output outside the block drives it.

The bus is not a stream. Every read and write finishes in the cycle its strobe is high, so there is no back-pressure. `bus_rdata` shows the addressed register at all times, and side effects happen only on the clock edge where `bus_rd` or `bus_wr` is high.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, the control and status registers read 0x00, SCK and MOSI are low and `irq` is low.
- R2: Address 0 is control, address 1 is status and address 2 is data. The control fields are: bits 1:0 rate select, bit 2 phase, bit 3 polarity, bit 4 host mode, bit 5 LSB-first, bit 6 enable and bit 7 interrupt enable. Control reads back exactly what was written. In status, only bit 0 (double rate) is writable; bits 7 and 6 ignore writes.
- R3: With phase 0, MISO is sampled and MOSI is valid on leading SCK edges, and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and data is sampled on trailing edges.
- R4: When no exchange is running, SCK rests at the polarity bit: high for 1, low for 0.
- R5: With LSB-first set, bit 0 of the byte goes out first and the first bit received lands in bit 0. With it clear, bit 7 goes out first and the first bit received lands in bit 7.
- R6: The SCK period is the system clock divided by 4, 16, 64 or 128 for rate select 00, 01, 10 or 11. The double-rate bit halves that divisor. The completion flag (status bit 7) reads 1 exactly 8 × divisor clock cycles after the cycle of the starting data write.
- R7: A data write starts an exchange only when both enable and host mode are set. Otherwise SCK does not move and the completion flag stays 0.
- R8: A data write during an exchange sets status bit 6 and is discarded. The exchange in progress keeps shifting the byte it started with.
- R9: The completion and collision flags are cleared only by a status read made while the completion flag is 1, followed by a data register access. A data access without that earlier status read leaves them set.
- R10: `irq` is high exactly while the completion flag and the interrupt enable bit are both 1.
- R11: A data register read returns the byte received in the last exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Addressed register contents |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that SCK rests at the polarity level while idle. They also check that the last shift edge raises the completion flag, that a data write during an exchange raises the collision flag, that no exchange begins while enable or host mode is clear, that `irq` never rises without its enable, and that rate ticks never come back to back unless the divisor calls for it. The bench scenarios cover what only a whole exchange can show: the actual MOSI bit sequence and the received byte in each phase, polarity and order combination, the exact length of an exchange for every divisor and the double-rate bit, the two-step flag clear with its negative case, and the survival of the original byte through a collision.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned MAX_EXP  = 6;   // largest half-period exponent (divide by 128)

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // Control register, most significant field first.
  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       host_mode;
    logic       polarity;
    logic       phase;
    logic [1:0] rate_sel;
  } ctrl_t;

  // log2 of the SCK half period in system clocks, before double rate.
  function automatic logic [2:0] half_exp(input logic [1:0] sel);
    case (sel)
      2'b00:   half_exp = 3'd1;
      2'b01:   half_exp = 3'd3;
      2'b10:   half_exp = 3'd5;
      default: half_exp = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/spi_host_rate.sv
module spi_host_rate
  import spi_host_pkg::*;
#(
  parameter int unsigned EXP_MAX = MAX_EXP
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       dbl,
  output logic       tick
);
  localparam int unsigned CW = EXP_MAX + 1;

  logic [2:0]    exp_eff;
  logic [CW-1:0] reload;
  logic [CW-1:0] cnt_q;

  always_comb begin
    exp_eff = half_exp(sel) - {2'b00, dbl};
    reload  = (CW'(1) << exp_eff) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= reload;
    else if (cnt_q == '0)    cnt_q <= reload;
    else                     cnt_q <= cnt_q - CW'(1);
  end

  assign tick = run && (cnt_q == '0);

  // R6: with a half period above one clock, edge ticks never come back to back
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && reload != '0) |=> !tick);
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine #(
  parameter int unsigned XFER_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 tick,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic                 lsb_first,
  input  logic [XFER_BITS-1:0] tx_byte,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done,
  output logic [XFER_BITS-1:0] rx_byte,
  output logic                 sck,
  output logic                 mosi
);
  localparam int unsigned EDGES = 2 * XFER_BITS;
  localparam int unsigned EW    = $clog2(EDGES);

  logic [EW-1:0]        edge_q;
  logic                 phase_q;
  logic                 busy_q;
  logic [XFER_BITS-1:0] tx_q;
  logic [XFER_BITS-1:0] rx_q;
  logic                 leading, last, sample_now, launch_now;

  always_comb begin
    leading    = ~edge_q[0];
    last       = (edge_q == EW'(EDGES - 1));
    sample_now = tick && (leading ^ cpha);
    launch_now = tick && (cpha ? (leading && edge_q != '0) : (!leading && !last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      edge_q  <= '0;
      phase_q <= 1'b0;
      tx_q    <= tx_byte;
    end else if (tick) begin
      phase_q <= ~phase_q;
      edge_q  <= last ? '0 : edge_q + EW'(1);
      if (launch_now)
        tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
      if (sample_now)
        rx_q <= lsb_first ? {miso, rx_q[XFER_BITS-1:1]} : {rx_q[XFER_BITS-2:0], miso};
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign done    = tick && last;
  assign rx_byte = rx_q;
  assign sck     = cpol ^ phase_q;
  assign mosi    = lsb_first ? tx_q[0] : tx_q[XFER_BITS-1];

  // R4: idle SCK level follows polarity
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == cpol));
  // R7: an accepted start always opens an exchange
  a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  // R6: the final edge ends the exchange
  a_r6_last_edge_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic              dbl_q, cpl_q, wcol_q, arm_q;
  logic              eng_busy, eng_done, eng_tick;
  logic [BYTE_W-1:0] eng_rx;
  logic              data_wr, data_touch, start, collide, stat_rd;

  always_comb begin
    data_wr    = bus_wr && (bus_addr == ADDR_DATA);
    data_touch = (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
    stat_rd    = bus_rd && (bus_addr == ADDR_STAT);
    start      = data_wr && ctrl_q.enable && ctrl_q.host_mode && !eng_busy;
    collide    = data_wr && eng_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dbl_q  <= 1'b0;
      cpl_q  <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (bus_wr && bus_addr == ADDR_STAT) dbl_q  <= bus_wdata[0];

      if (eng_done)                 cpl_q <= 1'b1;
      else if (arm_q && data_touch) cpl_q <= 1'b0;

      if (collide)                  wcol_q <= 1'b1;
      else if (arm_q && data_touch) wcol_q <= 1'b0;

      if (stat_rd && cpl_q)         arm_q <= 1'b1;
      else if (data_touch)          arm_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: bus_rdata = {cpl_q, wcol_q, 5'b0, dbl_q};
      ADDR_DATA: bus_rdata = eng_rx;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = cpl_q & ctrl_q.irq_en;

  spi_host_rate #(.EXP_MAX(MAX_EXP)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_busy),
    .sel  (ctrl_q.rate_sel),
    .dbl  (dbl_q),
    .tick (eng_tick)
  );

  spi_host_engine #(.XFER_BITS(BYTE_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (eng_tick),
    .cpol     (ctrl_q.polarity),
    .cpha     (ctrl_q.phase),
    .lsb_first(ctrl_q.lsb_first),
    .tx_byte  (bus_wdata),
    .miso     (miso),
    .busy     (eng_busy),
    .done     (eng_done),
    .rx_byte  (eng_rx),
    .sck      (sck),
    .mosi     (mosi)
  );

  // R6/R9: the engine's final edge raises the completion flag
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> cpl_q);
  // R8: a data write during an exchange marks a collision
  a_r8_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && eng_busy) |=> wcol_q);
  // R7: without enable and host mode, nothing starts
  a_r7_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !(ctrl_q.enable && ctrl_q.host_mode)) |=> !eng_busy);
  // R10: no request without its enable
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q.irq_en && cpl_q));
endmodule

// File: tb/test_spi_host_regs.sv
module test_spi_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  always #5 clk = ~clk;

  spi_host_regs i_spi_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] tx; logic [7:0] slv; } exp_t;
  exp_t q[$];
  logic m_cpha = 1'b0, m_lsb = 1'b0;
  logic m_dbl = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic sbit(input logic [7:0] b, input int k);
    return m_lsb ? b[k] : b[7-k];
  endfunction

  // Monitor: slave model and scoreboard for the MOSI stream
  int n = 0;
  logic [7:0] got;
  logic prev_sck = 1'b0;
  exp_t cur;
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        cur = q[0];
        if (n == 0 && !m_cpha) miso = sbit(cur.slv, 0);
        if (sck !== prev_sck) begin
          n++;
          if ((n % 2 == 1) != m_cpha) got[(n-1)/2] = mosi;
          if (!m_cpha && (n % 2 == 0) && n < 16) miso = sbit(cur.slv, n/2);
          if (m_cpha && (n % 2 == 1)) miso = sbit(cur.slv, (n-1)/2);
          if (n == 16) begin
            logic [7:0] byt;
            for (int k = 0; k < 8; k++) byt[m_lsb ? k : 7-k] = got[k];
            chk(byt == cur.tx, "R3 R5 mosi sequence", byt, cur.tx);
            void'(q.pop_front());
            n = 0;
          end
        end
      end
      prev_sck = sck;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] sel, input logic cpol, input logic cpha,
                          input logic lsb, input logic ien, input logic dbl);
    m_cpha = cpha; m_lsb = lsb; m_dbl = dbl;
    bus_write(2'd0, {ien, 1'b1, lsb, 1'b1, cpol, cpha, sel});
    bus_write(2'd1, {7'b0, dbl});
    @(negedge clk);
    chk(sck == cpol, "R4 idle level", sck, cpol);
  endtask

  // Starts the exchange, counts cycles until status bit 7 reads 1
  task automatic start_and_wait(input logic [7:0] tx, input logic [7:0] slv, output int cyc);
    exp_t e; e.tx = tx; e.slv = slv;
    q.push_back(e);
    bus_write(2'd2, tx);
    bus_addr = 2'd1; #1;
    cyc = 0;
    while (!bus_rdata[7]) begin
      cyc++;
      @(negedge clk); #1;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input int div, input logic ien);
    int cyc;
    logic [7:0] d;
    start_and_wait(tx, slv, cyc);
    chk(cyc == 8*div, "R6 exchange length", cyc, 8*div);
    chk(irq == ien, "R10 irq at completion", irq, ien);
    bus_read(2'd1, d);
    bus_read(2'd2, d);
    chk(d == slv, "R11 received byte", d, slv);
    bus_read(2'd1, d);
    chk(d == {7'b0, m_dbl}, "R9 flags cleared", d, {7'b0, m_dbl});
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cyc;
    int moves;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == 1'b0 && mosi == 1'b0 && irq == 1'b0, "R1 pins after reset", {sck, mosi, irq}, 0);
    bus_read(2'd0, d); chk(d == 8'h00, "R1 control after reset", d, 0);
    bus_read(2'd1, d); chk(d == 8'h00, "R1 status after reset", d, 0);

    // R2 register map
    bus_write(2'd0, 8'h53);
    bus_read(2'd0, d); chk(d == 8'h53, "R2 control readback", d, 8'h53);
    bus_write(2'd1, 8'hC1);
    bus_read(2'd1, d); chk(d == 8'h01, "R2 status write mask", d, 8'h01);
    bus_write(2'd1, 8'h00);

    // R3 R4 R5 modes at divide by 4
    set_mode(2'b00, 0, 0, 0, 0, 0); xfer(8'hDE, 8'h35, 4, 0);
    set_mode(2'b00, 0, 1, 0, 0, 0); xfer(8'hA5, 8'h3C, 4, 0);
    set_mode(2'b00, 1, 0, 0, 0, 0); xfer(8'h81, 8'h7E, 4, 0);
    set_mode(2'b00, 1, 1, 0, 0, 0); xfer(8'h5A, 8'hC3, 4, 0);
    set_mode(2'b00, 0, 0, 1, 0, 0); xfer(8'hDE, 8'h01, 4, 0);
    set_mode(2'b00, 1, 1, 1, 0, 0); xfer(8'h13, 8'hB4, 4, 0);

    // R6 rate selects and double rate
    set_mode(2'b01, 0, 0, 0, 0, 0); xfer(8'h69, 8'h96, 16, 0);
    set_mode(2'b10, 0, 1, 0, 0, 0); xfer(8'hF0, 8'h0F, 64, 0);
    set_mode(2'b11, 0, 0, 0, 0, 0); xfer(8'h3C, 8'hA7, 128, 0);
    set_mode(2'b00, 0, 0, 0, 0, 1); xfer(8'hC6, 8'h5D, 2, 0);
    set_mode(2'b01, 1, 0, 1, 0, 1); xfer(8'h2B, 8'hE4, 8, 0);

    // R10 interrupt enabled
    set_mode(2'b00, 0, 0, 0, 1, 0); xfer(8'h77, 8'h88, 4, 1);

    // R8 collision: second write is dropped
    set_mode(2'b00, 0, 0, 0, 0, 0);
    begin
      exp_t e; e.tx = 8'hB1; e.slv = 8'h4E; q.push_back(e);
    end
    bus_write(2'd2, 8'hB1);
    bus_write(2'd2, 8'h0F);
    bus_addr = 2'd1; #1;
    while (!bus_rdata[7]) begin @(negedge clk); #1; end
    @(negedge clk);
    bus_read(2'd1, d); chk(d == 8'hC0, "R8 collision flag", d, 8'hC0);
    bus_read(2'd2, d); chk(d == 8'h4E, "R8 R11 first byte kept", d, 8'h4E);
    bus_read(2'd1, d); chk(d == 8'h00, "R9 both flags cleared", d, 0);

    // R9 data access without prior status read keeps the flag
    start_and_wait(8'h5E, 8'hA1, cyc);
    bus_read(2'd2, d); chk(d == 8'hA1, "R11 received byte", d, 8'hA1);
    bus_read(2'd1, d); chk(d == 8'h80, "R9 flag kept without status read", d, 8'h80);
    bus_read(2'd2, d);
    bus_read(2'd1, d); chk(d == 8'h00, "R9 flag cleared by sequence", d, 0);

    // R7 no exchange without enable or host mode
    bus_write(2'd0, 8'h10);
    bus_write(2'd2, 8'hFF);
    moves = 0;
    for (int i = 0; i < 80; i++) begin
      logic s0;
      s0 = sck; @(negedge clk);
      if (sck !== s0) moves++;
    end
    chk(moves == 0, "R7 no SCK without enable", moves, 0);
    bus_read(2'd1, d); chk(d[7] == 1'b0, "R7 no completion without enable", d, 0);
    bus_write(2'd0, 8'h40);
    bus_write(2'd2, 8'hFF);
    moves = 0;
    for (int i = 0; i < 80; i++) begin
      logic s0;
      s0 = sck; @(negedge clk);
      if (sck !== s0) moves++;
    end
    chk(moves == 0, "R7 no SCK without host mode", moves, 0);
    bus_read(2'd1, d); chk(d[7] == 1'b0, "R7 no completion without host mode", d, 0);

    chk(q.size() == 0, "R3 all exchanges observed", q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule